// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, through a non-inverting path of configurable width (eight bits by default). Each direction has a holding register. A capture strobe loads the register for that direction. A per-direction source select decides whether the driven bus receives live pass-through data or the held value. One active-low enable and one direction input together choose which bus, if either, the block drives.

Each bus is split into an input, an output and an output-enable, and the tri-state pads sit outside the block. All logic runs on one system clock. The capture strobes are asynchronous level inputs: each passes through a two-flop synchronizer and a rising-edge detector. The register loads its bus value at the detected edge. Capture works whether or not the outputs are enabled, so values can be staged while both buses are isolated and driven out later.

Top module: `dual_hold_xcvr`

## Requirements
- R1: With `en_n`=0, `to_b`=1 and `a2b_use_store`=0, `b_oe` is 1 and `b_out` equals `a_in` bit for bit in the same cycle, without inversion.
- R2: With `en_n`=0, `to_b`=0 and `b2a_use_store`=0, `a_oe` is 1 and `a_out` equals `b_in` in the same cycle.
- R3: With `b_oe`=1 and `a2b_use_store`=1, `b_out` equals the A-side holding register.
- R4: With `a_oe`=1 and `b2a_use_store`=1, `a_out` equals the B-side holding register.
- R5: A rising edge on `grab_a` loads `a_in` into the A-side register. The strobe is raised before clock edge k and stays high for at least two cycles. The load happens at edge k+2, and the data must be stable through that edge. The new value appears on the stored path from then on.
- R6: A rising edge on `grab_b` loads `b_in` into the B-side register, with the same timing as R5.
- R7: While `en_n`=1, `a_oe` and `b_oe` are both 0. Both registers still capture, one at a time or both at once.
- R8: Capture ignores `en_n` and `to_b`. A strobe held high loads once, and later changes on the bus leave the register unchanged until the next rising edge.
- R9: `a_oe` and `b_oe` are never 1 at the same time. `a_oe` = !en_n & !to_b and `b_oe` = !en_n & to_b, both combinational.
- R10: A synchronous active-high `rst` clears both registers to zero and clears the strobe detectors. Reset has no effect on `a_oe` or `b_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Output enable, active low |
| to_b | input | 1 | Direction: 1 drives bus B, 0 drives bus A |
| a2b_use_store | input | 1 | Source for bus B: 0 live A, 1 A-side register |
| b2a_use_store | input | 1 | Source for bus A: 0 live B, 1 B-side register |
| grab_a | input | 1 | Capture strobe for the A-side register |
| grab_b | input | 1 | Capture strobe for the B-side register |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The enables and the live paths are combinational, so they are due in the same cycle as the stimulus. The bench drives controls on the falling edge and samples one nanosecond later. A capture takes effect at the third rising edge after the strobe is raised. The bench holds the bus data steady through that edge and reads the stored path only after two more falling edges. Bus data is compared only on a bus the block is driving. A strobe is never raised on a bus the block is driving, because the captured value is undefined in that case.

// File: rtl/dhx_pkg.sv
package dhx_pkg;
  localparam int DEF_W    = 8;
  localparam int DEF_SYNC = 2;

  // Drive enables packed as {b_oe, a_oe}.
  function automatic logic [1:0] oe_pair(input logic en_n, input logic to_b);
    oe_pair = {~en_n & to_b, ~en_n & ~to_b};
  endfunction
endpackage

// File: rtl/dhx_strobe_edge.sv
module dhx_strobe_edge #(
  parameter int SYNC = dhx_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic rise
);
  logic [SYNC:0] shf;

  always_ff @(posedge clk) begin
    if (rst) shf <= '0;
    else     shf <= {shf[SYNC-1:0], raw};
  end

  assign rise = shf[SYNC-1] & ~shf[SYNC];

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
endmodule

// File: rtl/dhx_hold_reg.sv
module dhx_hold_reg #(
  parameter int W = dhx_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (rst) cap |=> q == $past(d));
  // R8
  hold_value_chk: assert property (@(posedge clk) disable iff (rst) !cap |=> $stable(q));
  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> q == '0);
endmodule

// File: rtl/dhx_path_pick.sv
module dhx_path_pick #(
  parameter int W = dhx_pkg::DEF_W
) (
  input  logic         use_store,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] y
);
  always_comb begin
    if (use_store) y = held;
    else           y = live;
  end
endmodule

// File: rtl/dual_hold_xcvr.sv
module dual_hold_xcvr #(
  parameter int W    = dhx_pkg::DEF_W,
  parameter int SYNC = dhx_pkg::DEF_SYNC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         to_b,
  input  logic         a2b_use_store,
  input  logic         b2a_use_store,
  input  logic         grab_a,
  input  logic         grab_b,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int LANES = 2;  // lane 0: A toward B, lane 1: B toward A

  logic [LANES-1:0] lane_strobe;
  logic [LANES-1:0] lane_rise;
  logic [LANES-1:0] lane_sel;
  logic [W-1:0]     lane_src  [LANES];
  logic [W-1:0]     lane_held [LANES];
  logic [W-1:0]     lane_out  [LANES];
  logic [1:0]       oe_vec;

  assign lane_strobe = {grab_b, grab_a};
  assign lane_sel    = {b2a_use_store, a2b_use_store};
  assign lane_src[0] = a_in;
  assign lane_src[1] = b_in;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dhx_strobe_edge #(.SYNC(SYNC)) u_edge (
      .clk(clk), .rst(rst), .raw(lane_strobe[g]), .rise(lane_rise[g])
    );
    dhx_hold_reg #(.W(W)) u_hold (
      .clk(clk), .rst(rst), .cap(lane_rise[g]), .d(lane_src[g]), .q(lane_held[g])
    );
    dhx_path_pick #(.W(W)) u_pick (
      .use_store(lane_sel[g]), .live(lane_src[g]), .held(lane_held[g]), .y(lane_out[g])
    );
  end

  assign oe_vec = dhx_pkg::oe_pair(en_n, to_b);
  assign a_oe   = oe_vec[0];
  assign b_oe   = oe_vec[1];
  assign b_out  = lane_out[0];
  assign a_out  = lane_out[1];

  // R9
  oe_exclusive_chk: assert property (@(posedge clk) $onehot0({a_oe, b_oe}));
  // R7
  isolate_chk: assert property (@(posedge clk) en_n |-> (!a_oe && !b_oe));
  // R1
  live_ab_chk: assert property (@(posedge clk) (b_oe && !a2b_use_store) |-> b_out == a_in);
  // R4
  stored_ba_chk: assert property (@(posedge clk) (a_oe && b2a_use_store) |-> a_out == lane_held[1]);
endmodule

// File: tb/dual_hold_xcvr_test.sv
module dual_hold_xcvr_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       en_n = 1, to_b = 0, sab = 0, sba = 0, grab_a = 0, grab_b = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;
  logic [7:0] ma = 0, mb = 0;  // model of the two holding registers
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dual_hold_xcvr uut (
    .clk(clk), .rst(rst), .en_n(en_n), .to_b(to_b),
    .a2b_use_store(sab), .b2a_use_store(sba),
    .grab_a(grab_a), .grab_b(grab_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [7:0] want_data(logic pick_store, logic [7:0] live, logic [7:0] held);
    return (held & {8{pick_store}}) | (live & {8{~pick_store}});
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_now(input string req);
    logic eb, ea;
    eb = (en_n == 0) && (to_b == 1);
    ea = (en_n == 0) && (to_b == 0);
    chk(b_oe == eb, {req, " b_oe"}, b_oe, eb);
    chk(a_oe == ea, {req, " a_oe"}, a_oe, ea);
    if (eb) chk(b_out == want_data(sab, a_in, ma), {req, " b_out"}, b_out, want_data(sab, a_in, ma));
    if (ea) chk(a_out == want_data(sba, b_in, mb), {req, " a_out"}, a_out, want_data(sba, b_in, mb));
  endtask

  task automatic drive(input logic e, input logic d, input logic s1, input logic s2,
                       input logic [7:0] va, input logic [7:0] vb);
    @(negedge clk);
    en_n = e; to_b = d; sab = s1; sba = s2; a_in = va; b_in = vb;
    #1;
  endtask

  task automatic capture(input logic da, input logic db, input logic [7:0] va, input logic [7:0] vb);
    @(negedge clk);
    a_in = va; b_in = vb; grab_a = da; grab_b = db;
    repeat (3) @(negedge clk);
    grab_a = 0; grab_b = 0;
    repeat (2) @(negedge clk);
    if (da) ma = va;
    if (db) mb = vb;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10: oe follows controls even in reset
    en_n = 0; to_b = 1; #1;
    chk(b_oe == 1 && a_oe == 0, "R10 oe during reset", {a_oe, b_oe}, 2'b01);
    @(negedge clk); rst = 0;
    // R10: registers cleared, seen through stored paths
    drive(0, 1, 1, 0, 8'hff, 8'h00);
    chk(b_out == 8'h00, "R10 A reg cleared", b_out, 0);
    drive(0, 0, 0, 1, 8'h00, 8'hff);
    chk(a_out == 8'h00, "R10 B reg cleared", a_out, 0);
    // R1 / R2 live paths
    drive(0, 1, 0, 0, 8'ha5, 8'h3c); check_now("R1 live A to B");
    drive(0, 0, 0, 0, 8'h5a, 8'hc3); check_now("R2 live B to A");
    // R7 isolation, capture both at once
    drive(1, 0, 0, 0, 8'h00, 8'h00); check_now("R7 isolate");
    capture(1, 1, 8'h96, 8'h69);
    drive(1, 1, 1, 1, 8'h11, 8'h22); check_now("R7 isolated with stored sel");
    // R3 / R4 stored paths
    drive(0, 1, 1, 0, 8'h11, 8'h22);
    chk(b_out == 8'h96, "R3 stored A to B", b_out, 8'h96);
    drive(0, 0, 0, 1, 8'h11, 8'h22);
    chk(a_out == 8'h69, "R4 stored B to A", a_out, 8'h69);
    // R5 single capture of A while B is driven (A undriven)
    en_n = 0; to_b = 1; sab = 1;
    capture(1, 0, 8'h3e, 8'h00);
    #1 chk(b_out == 8'h3e, "R5 capture A while enabled", b_out, 8'h3e);
    // R6 single capture of B while A is driven (B undriven)
    en_n = 0; to_b = 0; sba = 1;
    capture(0, 1, 8'h00, 8'he7);
    #1 chk(a_out == 8'he7, "R6 capture B while enabled", a_out, 8'he7);
    // R8 strobe held high: one load only
    en_n = 1;
    @(negedge clk); a_in = 8'h42; grab_a = 1;
    repeat (4) @(negedge clk);
    ma = 8'h42;
    a_in = 8'hbd;
    repeat (6) @(negedge clk);
    grab_a = 0;
    drive(0, 1, 1, 0, 8'hbd, 8'h00);
    chk(b_out == 8'h42, "R8 held strobe no reload", b_out, 8'h42);
    // R8 capture with no strobe edge leaves register unchanged
    drive(0, 1, 1, 0, 8'h77, 8'h00); repeat (3) @(negedge clk); #1;
    chk(b_out == 8'h42, "R8 no edge no load", b_out, 8'h42);
    // R9 all enable combinations
    for (int k = 0; k < 4; k++) begin
      drive(k[1], k[0], 0, 0, 8'h0f, 8'hf0);
      chk(!(a_oe && b_oe), "R9 exclusive", {a_oe, b_oe}, 0);
      check_now("R9 combo");
    end
    // random mix: R1 R2 R3 R4 R7, periodic isolated captures (R5 R6)
    for (int i = 0; i < 80; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(r[0], r[1], r[2], r[3], 8'($urandom), 8'($urandom));
      check_now("R1-mix random");
      if (i % 8 == 7) begin
        logic [1:0] w;
        w = 2'($urandom);
        if (w == 0) w = 2'b11;
        en_n = 1;
        capture(w[0], w[1], 8'($urandom), 8'($urandom));
      end
    end
    // R10 reset mid-run clears registers
    @(negedge clk); rst = 1; en_n = 0; to_b = 0; #1;
    chk(a_oe == 1, "R10 oe unaffected", a_oe, 1);
    @(negedge clk); rst = 0; ma = 0; mb = 0;
    drive(0, 0, 0, 1, 8'h00, 8'h55);
    chk(a_out == 8'h00, "R10 reset clears B reg", a_out, 0);
    finish_up();
  end
endmodule